// File: doc/BRIEF.md
# Serial Command Front-End for a Shadowed Word Memory

This block is the serial slave side of a small word memory, 16 words of 16 bits, that a separate controller keeps backed by a nonvolatile copy. A host drives chip select, a serial clock and a serial data line. The block watches for a start bit and assembles an 8-bit instruction. It then does one of two things: it performs a word read or write against its local RAM, or it sends a single-cycle command pulse to the protection controller. The protection latches and the store/recall sequencing live in that controller, not here.

All serial inputs are resynchronised into the system clock domain, and the block acts on the detected edges of the serial clock. Because it works only on edges, the host may stop the serial clock between any two bits without losing state. Serial output is a data bit plus an output-enable. Outside the read data phase the enable is low, and a pad or the board treats that as high impedance.

Top module: `nvsf_serial_front`

## Requirements
- R1: While chip select is low, zero bits seen on the data input before the first one bit are discarded. That first one bit becomes bit 7 of the instruction.
- R2: The instruction is 8 bits, sent MSB first and sampled on rising serial-clock edges. Bits 6..3 hold the word address. Bits 2..0 hold the opcode.
- R3: Each of these opcodes produces exactly one single-cycle pulse on its own output, with no pulse on any other command output: 000 write-disable, 001 store, 010 autostore-enable, 100 write-enable, 101 recall.
- R4: Opcode 011 is a write. It is followed by a 16-bit data word sent MSB first. The word is committed to the addressed RAM word when chip select rises.
- R5: If chip select rises after k data bits, where 0 < k < 16, those k bits replace the top k bits of the word and the lower bits keep their stored value. If k = 0, nothing is written.
- R6: If more than 16 data bits are clocked in, the word written is made of the last 16 bits received.
- R7: Opcodes 110 and 111 are reads, so bit 0 is ignored. The output enable rises on the falling edge that follows the 8th rising edge. The output then carries bit 15 first, and each later falling edge moves it to the next lower bit.
- R8: The output enable is low except during the read data phase. Raising chip select resets the instruction and returns the output to high impedance.
- R9: While the busy input is high, no command pulse is produced, no write is committed and the output enable stays low, for the rest of that chip-select frame.
- R10: A write is committed only if the write-enable input is high when chip select rises. Otherwise the RAM word keeps its value.
- R11: The serial clock may be held still for any time between bits, and the transfer continues correctly when it resumes.
- R12: After reset the output enable and all command outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, sampled in the clk domain |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Serial data out enable; low means high impedance |
| busy_i | input | 1 | Controller busy (store, recall or power-up recall) |
| wr_en_i | input | 1 | Controller write-enable latch state |
| cmd_wrdis | output | 1 | Write-disable command pulse |
| cmd_store | output | 1 | Store command pulse |
| cmd_autoen | output | 1 | Autostore-enable command pulse |
| cmd_wren | output | 1 | Write-enable command pulse |
| cmd_recall | output | 1 | Recall command pulse |

## Verification
The block sees a serial-clock edge three system clocks after the host makes it: two synchroniser stages and then the state register. So command pulses and output-enable changes appear three clocks after the causing edge. A RAM commit lands two clocks after the synchronised chip-select rise is seen. The bench holds every serial-clock phase for six system clocks and samples the output at the end of the low phase, just before each rising edge. This leaves margin past that latency, so the ninth sample is the first that must show data. Pulse counts are taken over a whole frame, and committed words are checked only after chip select has stayed high for twenty clocks.

// File: rtl/nvsf_pkg.sv
package nvsf_pkg;

   typedef enum logic [2:0] {
      OP_WRDIS  = 3'b000,
      OP_STORE  = 3'b001,
      OP_AUTOEN = 3'b010,
      OP_WRITE  = 3'b011,
      OP_WREN   = 3'b100,
      OP_RECALL = 3'b101,
      OP_READA  = 3'b110,
      OP_READB  = 3'b111
   } opcode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_INS,
      ST_WDATA,
      ST_RWAIT,
      ST_ROUT,
      ST_DROP
   } fe_state_e;

endpackage

// File: rtl/nvsf_sync_edge.sv
module nvsf_sync_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic sdi,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_hi,
   output logic sdi_s
);
   // lane order in each stage: {sck, cs_n, sdi}
   localparam logic [2:0] RST_VAL = 3'b010;

   logic [SYNC_STAGES-1:0][2:0] stg;
   logic                        sck_prev;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("nvsf_sync_edge: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg      <= {SYNC_STAGES{RST_VAL}};
         sck_prev <= 1'b0;
      end else begin
         stg      <= {stg[SYNC_STAGES-2:0], {sck, cs_n, sdi}};
         sck_prev <= stg[SYNC_STAGES-1][2];
      end
   end

   assign sck_rise =  stg[SYNC_STAGES-1][2] & ~sck_prev;
   assign sck_fall = ~stg[SYNC_STAGES-1][2] &  sck_prev;
   assign cs_hi    =  stg[SYNC_STAGES-1][1];
   assign sdi_s    =  stg[SYNC_STAGES-1][0];
endmodule

// File: rtl/nvsf_word_ram.sv
module nvsf_word_ram #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] wmask,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (DEPTH > 4096) begin : g_bad_depth
         $error("nvsf_word_ram: ADDR_W too large for a register array");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/nvsf_serial_front.sv
module nvsf_serial_front
   import nvsf_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic sdi,
   output logic sdo,
   output logic sdo_oe,
   input  logic busy_i,
   input  logic wr_en_i,
   output logic cmd_wrdis,
   output logic cmd_store,
   output logic cmd_autoen,
   output logic cmd_wren,
   output logic cmd_recall
);
   localparam int INS_W  = ADDR_W + 4;
   localparam int ICNT_W = $clog2(INS_W + 1);
   localparam int DCNT_W = $clog2(DATA_W + 1);
   localparam logic [ICNT_W-1:0] SEVENTH = ICNT_W'(INS_W - 2);
   localparam logic [ICNT_W-1:0] EIGHTH  = ICNT_W'(INS_W - 1);
   localparam logic [DCNT_W-1:0] DFULL   = DCNT_W'(DATA_W);

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("nvsf_serial_front: DATA_W must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("nvsf_serial_front: ADDR_W must be at least 1");
      end
   endgenerate

   logic sck_rise, sck_fall, cs_hi, sdi_s;

   nvsf_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck      (sck),
      .cs_n     (cs_n),
      .sdi      (sdi),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall),
      .cs_hi    (cs_hi),
      .sdi_s    (sdi_s)
   );

   fe_state_e          state;
   logic [INS_W-1:0]   ins;
   logic [INS_W-1:0]   ins_nxt;
   logic [ICNT_W-1:0]  icnt;
   logic [DATA_W-1:0]  dsh;
   logic [DCNT_W-1:0]  dcnt;
   logic [ADDR_W-1:0]  waddr_hold;
   logic [DATA_W-1:0]  rsh;
   logic               oe_q, sdo_q;

   logic               ram_we;
   logic [ADDR_W-1:0]  ram_waddr;
   logic [DATA_W-1:0]  ram_wdata, ram_wmask;
   logic [ADDR_W-1:0]  ram_raddr;
   logic [DATA_W-1:0]  ram_rdata;

   logic [DCNT_W-1:0]  align_sh;
   logic [DATA_W-1:0]  commit_data, commit_mask;
   logic [4:0]         pulse_d, pulse_q;
   opcode_e            op8;

   assign ins_nxt   = {ins[INS_W-2:0], sdi_s};
   assign ram_raddr = ins_nxt[ADDR_W+1:2];
   assign op8       = opcode_e'(ins_nxt[2:0]);

   // received bits sit at the bottom of dsh; move them to the top
   assign align_sh    = DFULL - dcnt;
   assign commit_data = dsh << align_sh;
   assign commit_mask = ~({DATA_W{1'b1}} >> dcnt);

   always_comb begin
      pulse_d = '0;
      if (!cs_hi && !busy_i && state == ST_INS && sck_rise && icnt == EIGHTH) begin
         unique case (op8)
            OP_WRDIS:  pulse_d[0] = 1'b1;
            OP_STORE:  pulse_d[1] = 1'b1;
            OP_AUTOEN: pulse_d[2] = 1'b1;
            OP_WREN:   pulse_d[3] = 1'b1;
            OP_RECALL: pulse_d[4] = 1'b1;
            default:   pulse_d    = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         ins        <= '0;
         icnt       <= '0;
         dsh        <= '0;
         dcnt       <= '0;
         waddr_hold <= '0;
         rsh        <= '0;
         oe_q       <= 1'b0;
         sdo_q      <= 1'b0;
         ram_we     <= 1'b0;
         ram_waddr  <= '0;
         ram_wdata  <= '0;
         ram_wmask  <= '0;
         pulse_q    <= '0;
      end else begin
         ram_we  <= 1'b0;
         pulse_q <= pulse_d;
         if (cs_hi) begin
            if (state == ST_WDATA && dcnt != '0 && wr_en_i && !busy_i) begin
               ram_we    <= 1'b1;
               ram_waddr <= waddr_hold;
               ram_wdata <= commit_data;
               ram_wmask <= commit_mask;
            end
            state <= ST_IDLE;
            ins   <= '0;
            icnt  <= '0;
            oe_q  <= 1'b0;
            sdo_q <= 1'b0;
         end else if (busy_i) begin
            state <= ST_DROP;
            oe_q  <= 1'b0;
            sdo_q <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: begin
                  if (sck_rise && sdi_s) begin
                     ins   <= {{(INS_W-1){1'b0}}, 1'b1};
                     icnt  <= ICNT_W'(1);
                     state <= ST_INS;
                  end
               end
               ST_INS: begin
                  if (sck_rise) begin
                     ins  <= ins_nxt;
                     icnt <= icnt + ICNT_W'(1);
                     if (icnt == SEVENTH && ins_nxt[1:0] == 2'b11) begin
                        rsh   <= ram_rdata;
                        state <= ST_RWAIT;
                     end else if (icnt == EIGHTH) begin
                        if (op8 == OP_WRITE) begin
                           waddr_hold <= ins_nxt[ADDR_W+2:3];
                           dcnt       <= '0;
                           state      <= ST_WDATA;
                        end else begin
                           state <= ST_DROP;
                        end
                     end
                  end
               end
               ST_WDATA: begin
                  if (sck_rise) begin
                     dsh <= {dsh[DATA_W-2:0], sdi_s};
                     if (dcnt != DFULL) dcnt <= dcnt + DCNT_W'(1);
                  end
               end
               ST_RWAIT: begin
                  if (sck_rise) state <= ST_ROUT;
               end
               ST_ROUT: begin
                  if (sck_fall) begin
                     oe_q  <= 1'b1;
                     sdo_q <= rsh[DATA_W-1];
                     rsh   <= {rsh[DATA_W-2:0], rsh[DATA_W-1]};
                  end
               end
               default: ;
            endcase
         end
      end
   end

   nvsf_word_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (ram_waddr),
      .wdata (ram_wdata),
      .wmask (ram_wmask),
      .raddr (ram_raddr),
      .rdata (ram_rdata)
   );

   assign sdo        = sdo_q;
   assign sdo_oe     = oe_q;
   assign cmd_wrdis  = pulse_q[0];
   assign cmd_store  = pulse_q[1];
   assign cmd_autoen = pulse_q[2];
   assign cmd_wren   = pulse_q[3];
   assign cmd_recall = pulse_q[4];
endmodule

// File: rtl/nvsf_serial_front_chk.sv
module nvsf_serial_front_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_hi,
   input logic       sck_fall,
   input logic       busy_i,
   input logic       wr_en_i,
   input logic       sdo_oe,
   input logic       ram_we,
   input logic [4:0] cmd_vec
);
   a_r8_cs_high_tristate: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi |=> !sdo_oe);

   a_r9_busy_no_output: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> !sdo_oe);

   a_r9_busy_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> (cmd_vec == 5'b0));

   a_r3_cmd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_vec));

   a_r3_cmd_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vec != 5'b0) |=> (cmd_vec == 5'b0));

   a_r10_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> $past(wr_en_i));

   a_r7_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> $past(sck_fall));
endmodule

bind nvsf_serial_front nvsf_serial_front_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_hi    (cs_hi),
   .sck_fall (sck_fall),
   .busy_i   (busy_i),
   .wr_en_i  (wr_en_i),
   .sdo_oe   (sdo_oe),
   .ram_we   (ram_we),
   .cmd_vec  ({cmd_recall, cmd_wren, cmd_autoen, cmd_store, cmd_wrdis})
);

// File: tb/nvsf_serial_front_tb.sv
module nvsf_serial_front_tb;
   localparam int CLK_P = 10;
   localparam int HALF  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
   logic busy_i = 1'b0, wr_en_i = 1'b1;
   logic sdo, sdo_oe;
   logic cmd_wrdis, cmd_store, cmd_autoen, cmd_wren, cmd_recall;

   int checks = 0;
   int fails  = 0;
   int pc [5];
   logic [47:0] rx_d, rx_oe;

   always #(CLK_P/2) clk = ~clk;

   nvsf_serial_front u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .busy_i(busy_i), .wr_en_i(wr_en_i),
      .cmd_wrdis(cmd_wrdis), .cmd_store(cmd_store), .cmd_autoen(cmd_autoen),
      .cmd_wren(cmd_wren), .cmd_recall(cmd_recall)
   );

   always @(posedge clk) begin
      if (cmd_wrdis)  pc[0] <= pc[0] + 1;
      if (cmd_store)  pc[1] <= pc[1] + 1;
      if (cmd_autoen) pc[2] <= pc[2] + 1;
      if (cmd_wren)   pc[3] <= pc[3] + 1;
      if (cmd_recall) pc[4] <= pc[4] + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame_start();
      rx_d = '0; rx_oe = '0;
      @(negedge clk); cs_n = 1'b0; idle(10);
   endtask

   task automatic frame_end();
      @(negedge clk); cs_n = 1'b1; sdi = 1'b0; idle(20);
   endtask

   // send n bits of v, MSB first, sampling output just before each rise
   task automatic send(input logic [47:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk); sdi = v[i];
         idle(HALF);
         rx_d  = {rx_d[46:0], sdo};
         rx_oe = {rx_oe[46:0], sdo_oe};
         sck = 1'b1; idle(HALF);
         sck = 1'b0;
      end
   endtask

   function automatic logic [7:0] ins(input logic [3:0] a, input logic [2:0] op);
      return {1'b1, a, op};
   endfunction

   task automatic wr_word(input logic [3:0] a, input logic [15:0] d);
      frame_start(); send({40'd0, ins(a, 3'b011)}, 8); send({32'd0, d}, 16); frame_end();
   endtask

   task automatic rd_word(input logic [3:0] a, input logic b0, output logic [15:0] d, output logic oe_ok);
      frame_start();
      send({40'd0, 1'b1, a, 2'b11, b0}, 8);
      send('0, 16);
      d = rx_d[15:0];
      oe_ok = (rx_oe[23:16] == 8'h00) && (rx_oe[15:0] == 16'hFFFF);
      frame_end();
   endtask

   task automatic t_reset();
      chk("R12 oe after reset", sdo_oe, 0);
      chk("R12 cmds after reset", {cmd_wrdis, cmd_store, cmd_autoen, cmd_wren, cmd_recall}, 0);
   endtask

   task automatic t_write_read();
      logic [15:0] d; logic ok;
      wr_word(4'h3, 16'hBEEF);
      chk("R8 oe low during write", rx_oe[23:0], 0);
      rd_word(4'h3, 1'b0, d, ok);
      chk("R4 R2 write then read addr3", d, 16'hBEEF);
      chk("R7 oe timing on read", ok, 1);
      rd_word(4'h3, 1'b1, d, ok);
      chk("R7 read bit0 ignored", d, 16'hBEEF);
      wr_word(4'hC, 16'h0F0F);
      rd_word(4'hC, 1'b0, d, ok);
      chk("R2 second address", d, 16'h0F0F);
   endtask

   task automatic t_hunt();
      logic [15:0] d; logic ok;
      frame_start();
      send('0, 5);
      send({40'd0, ins(4'h5, 3'b011)}, 8);
      send({32'd0, 16'h1234}, 16);
      frame_end();
      rd_word(4'h5, 1'b0, d, ok);
      chk("R1 leading zeros skipped", d, 16'h1234);
   endtask

   task automatic t_cmds();
      logic [2:0] ops [5] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101};
      for (int k = 0; k < 5; k++) begin
         for (int j = 0; j < 5; j++) pc[j] = 0;
         frame_start(); send({40'd0, ins(4'(k * 3), ops[k])}, 8); frame_end();
         for (int j = 0; j < 5; j++)
            chk($sformatf("R3 op %b pulse count on output %0d", ops[k], j), pc[j], (j == k) ? 1 : 0);
      end
   endtask

   task automatic t_trunc();
      logic [15:0] d; logic ok;
      wr_word(4'h7, 16'hFFFF);
      frame_start(); send({40'd0, ins(4'h7, 3'b011)}, 8); send({43'd0, 5'b10101}, 5); frame_end();
      rd_word(4'h7, 1'b0, d, ok);
      chk("R5 five-bit truncated write", d, 16'hAFFF);
      frame_start(); send({40'd0, ins(4'h7, 3'b011)}, 8); frame_end();
      rd_word(4'h7, 1'b0, d, ok);
      chk("R5 zero data bits no change", d, 16'hAFFF);
   endtask

   task automatic t_overlong();
      logic [15:0] d; logic ok;
      frame_start(); send({40'd0, ins(4'h8, 3'b011)}, 8); send({24'd0, 24'h123456}, 24); frame_end();
      rd_word(4'h8, 1'b0, d, ok);
      chk("R6 last sixteen bits kept", d, 16'h3456);
   endtask

   task automatic t_wr_disabled();
      logic [15:0] d; logic ok;
      wr_en_i = 1'b0;
      wr_word(4'h3, 16'h0000);
      wr_en_i = 1'b1;
      rd_word(4'h3, 1'b0, d, ok);
      chk("R10 write suppressed", d, 16'hBEEF);
   endtask

   task automatic t_busy();
      logic [15:0] d; logic ok;
      busy_i = 1'b1;
      for (int j = 0; j < 5; j++) pc[j] = 0;
      frame_start(); send({40'd0, ins(4'h0, 3'b100)}, 8); frame_end();
      chk("R9 no pulse while busy", pc[3], 0);
      rd_word(4'h3, 1'b0, d, ok);
      chk("R9 no output while busy", rx_oe[23:0], 0);
      wr_word(4'h3, 16'h1111);
      busy_i = 1'b0;
      rd_word(4'h3, 1'b0, d, ok);
      chk("R9 no write while busy", d, 16'hBEEF);
   endtask

   task automatic t_stall();
      logic [15:0] d;
      frame_start();
      send({44'd0, 4'b1100}, 4); idle(300);
      send({44'd0, 4'b1011}, 4);
      send({38'd0, 10'b0101101001}, 10); idle(300);
      send({42'd0, 6'b011010}, 6);
      frame_end();
      frame_start();
      send({40'd0, 8'b11001111}, 8);
      send('0, 6); idle(300);
      send('0, 10);
      d = rx_d[15:0];
      frame_end();
      chk("R11 stalled clock transfer", d, 16'h5A5A);
   endtask

   task automatic t_cs_abort();
      frame_start();
      send({40'd0, ins(4'h3, 3'b111)}, 8);
      send('0, 4);
      chk("R7 oe high mid read", sdo_oe, 1);
      @(negedge clk); cs_n = 1'b1; idle(10);
      chk("R8 oe low after cs high", sdo_oe, 0);
      idle(10);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int j = 0; j < 5; j++) pc[j] = 0;
      idle(5); rst_n = 1'b1; idle(5);
      t_reset();
      t_write_read();
      t_hunt();
      t_cmds();
      t_trunc();
      t_overlong();
      t_wr_disabled();
      t_busy();
      t_stall();
      t_cs_abort();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule